// File: doc/BRIEF.md
# Direct Page Address Expander

This block holds the base page used by direct-mode memory accesses. The base page is a single 8-bit register on a small peripheral register port. When the CPU makes a direct-mode access, the block joins that page with the 8-bit operand from the instruction to form a 16-bit address inside a 256-byte window. It then widens that address to 23 bits for the global memory map. For a global instruction the upper seven bits come from the global page input. For an ordinary local access they come from an external local-expansion input, which the block passes through unchanged.

The register resets to zero and can be read at any time. In special mode software may rewrite it freely. In normal mode only the first write after reset is accepted. That write sets a lock that only reset clears, and later normal-mode writes are ignored. Both address outputs are combinational from the register and the CPU-side inputs, so a value written on one clock edge appears on them in the following cycle.

Top module: `dpx_unit`

## Requirements
- R1: After reset the page register reads 0x00 and the lock is clear, so the next normal-mode write is accepted.
- R2: `reg_rdata` returns the page register in the same cycle when `reg_addr` is 0x11, and 0x00 for every other offset.
- R3: A write to offset 0x11 with `special_mode` = 1 always loads `reg_wdata`, any number of times and whether or not the lock is set.
- R4: With `special_mode` = 0, the first write to offset 0x11 after reset loads the register and sets the lock. Every later normal-mode write leaves the register unchanged until reset.
- R5: Changing `special_mode` does not clear the lock. A special-mode write neither sets nor clears it.
- R6: A write to any offset other than 0x11 changes neither the register nor the lock.
- R7: `local_addr` = {page register, `cpu_offset`}, with the page in bits [15:8] and the operand in bits [7:0].
- R8: `global_addr`[15:0] equals `local_addr`. `global_addr`[22:16] equals `gpage_in` when `cpu_global` = 1 and `lx_upper` when `cpu_global` = 0.
- R9: An accepted write appears on `reg_rdata`, `local_addr` and `global_addr` in the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register port offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| special_mode | input | 1 | 1 = special mode (unlimited writes), 0 = normal mode |
| gpage_in | input | 7 | Global page used for global instructions |
| lx_upper | input | 7 | Upper bits supplied by the external local expansion |
| cpu_offset | input | 8 | Direct operand from the instruction |
| cpu_global | input | 1 | 1 = global instruction, 0 = local access |
| local_addr | output | 16 | Direct-mode local address |
| global_addr | output | 23 | Direct-mode global address |

## Verification
The bench goes after the lock: a second normal-mode write, a special-mode write while the lock is set, and a switch of mode in both directions. A design that locked on special writes, or cleared the lock on a mode change, would keep a stale page or take a page it should have dropped. It also writes to neighbouring offsets, where a loose address decode would load the register or set the lock. Random operands and page inputs, with both values of the global flag, catch swapped or misplaced address fields and a wrong choice of the upper-bit source.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
    localparam int PAGE_W    = 8;
    localparam int OPER_W    = 8;
    localparam int GPAGE_W   = 7;
    localparam int REG_AW    = 8;
    localparam int LOCAL_W   = PAGE_W + OPER_W;
    localparam int GLOBAL_W  = GPAGE_W + LOCAL_W;
    localparam logic [REG_AW-1:0] PAGE_REG_OFS = 8'h11;

    typedef enum logic { MODE_NORMAL = 1'b0, MODE_SPECIAL = 1'b1 } run_mode_e;

    typedef enum logic [1:0] { WR_IDLE, WR_TAKE_LOCK, WR_TAKE_FREE, WR_DROP } wr_action_e;

    typedef struct packed {
        logic               is_global;
        logic [OPER_W-1:0]  offset;
        logic [GPAGE_W-1:0] gpage;
        logic [GPAGE_W-1:0] lx_upper;
    } cpu_req_t;

    typedef struct packed {
        logic [GLOBAL_W-1:0] glob;
        logic [LOCAL_W-1:0]  loc;
    } addr_out_t;

    function automatic logic [LOCAL_W-1:0] join_local(
        input logic [PAGE_W-1:0] page, input logic [OPER_W-1:0] ofs);
        return {page, ofs};
    endfunction

    function automatic logic [GLOBAL_W-1:0] widen_global(
        input logic [LOCAL_W-1:0] loc, input cpu_req_t req);
        return {(req.is_global ? req.gpage : req.lx_upper), loc};
    endfunction
endpackage

// File: rtl/dpx_page_reg.sv
module dpx_page_reg
    import dpx_pkg::*;
#(
    parameter logic [REG_AW-1:0] OFFSET = PAGE_REG_OFS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [PAGE_W-1:0] reg_wdata,
    input  run_mode_e         mode,
    output logic [PAGE_W-1:0] reg_rdata,
    output logic [PAGE_W-1:0] page_q
);
    logic       lock_q;
    logic       hit;
    wr_action_e act;

    assign hit = (reg_addr == OFFSET);

    always_comb begin
        act = WR_IDLE;
        if (reg_wr && hit) begin
            if (mode == MODE_SPECIAL) act = WR_TAKE_FREE;
            else if (!lock_q)         act = WR_TAKE_LOCK;
            else                      act = WR_DROP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            lock_q <= 1'b0;
        end else begin
            case (act)
                WR_TAKE_FREE: page_q <= reg_wdata;
                WR_TAKE_LOCK: begin
                    page_q <= reg_wdata;
                    lock_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign reg_rdata = hit ? page_q : '0;

    // R3: special-mode writes always load
    assert_special_load_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && hit && mode == MODE_SPECIAL) |=> (page_q == $past(reg_wdata)));

    // R4: a locked normal-mode write is dropped
    assert_locked_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && hit && mode == MODE_NORMAL && lock_q) |=> $stable(page_q));

    // R5: the lock never clears outside reset
    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    // R6: no write at this offset leaves the register and the lock alone
    assert_miss_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && hit) |=> ($stable(page_q) && $stable(lock_q)));
endmodule

// File: rtl/dpx_addr_compose.sv
module dpx_addr_compose
    import dpx_pkg::*;
(
    input  logic [PAGE_W-1:0] page,
    input  cpu_req_t          req,
    output addr_out_t         addr
);
    logic [LOCAL_W-1:0] loc;

    assign loc       = join_local(page, req.offset);
    assign addr.loc  = loc;
    assign addr.glob = widen_global(loc, req);
endmodule

// File: rtl/dpx_unit.sv
module dpx_unit
    import dpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [PAGE_W-1:0]   reg_wdata,
    output logic [PAGE_W-1:0]   reg_rdata,
    input  logic                special_mode,
    input  logic [GPAGE_W-1:0]  gpage_in,
    input  logic [GPAGE_W-1:0]  lx_upper,
    input  logic [OPER_W-1:0]   cpu_offset,
    input  logic                cpu_global,
    output logic [LOCAL_W-1:0]  local_addr,
    output logic [GLOBAL_W-1:0] global_addr
);
    logic [PAGE_W-1:0] page;
    run_mode_e         mode;
    cpu_req_t          req;
    addr_out_t         addr;

    assign mode = special_mode ? MODE_SPECIAL : MODE_NORMAL;
    assign req  = '{is_global: cpu_global, offset: cpu_offset,
                    gpage: gpage_in, lx_upper: lx_upper};

    dpx_page_reg #(.OFFSET(PAGE_REG_OFS)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .mode     (mode),
        .reg_rdata(reg_rdata),
        .page_q   (page)
    );

    dpx_addr_compose u_cmp (
        .page(page),
        .req (req),
        .addr(addr)
    );

    assign local_addr  = addr.loc;
    assign global_addr = addr.glob;

    // R2: the read port and the address path see the same page
    assert_read_match_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == PAGE_REG_OFS) |-> (reg_rdata == local_addr[LOCAL_W-1:OPER_W]));

    // R8: upper global bits follow the selected source
    assert_gpage_sel_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_global |-> (global_addr[GLOBAL_W-1:LOCAL_W] == gpage_in));
endmodule

// File: tb/tb_dpx_unit.sv
`timescale 1ns/1ps
module tb_dpx_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        special_mode = 1'b0;
    logic [6:0]  gpage_in = 7'h00;
    logic [6:0]  lx_upper = 7'h00;
    logic [7:0]  cpu_offset = 8'h00;
    logic        cpu_global = 1'b0;
    logic [15:0] local_addr;
    logic [22:0] global_addr;

    int total = 0;
    int bad = 0;
    logic [7:0] mdl_page = 8'h00;
    logic       mdl_lock = 1'b0;
    localparam logic [7:0] OFS = 8'h11;

    always #2.5 clk = ~clk;

    dpx_unit dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_local(input logic [7:0] pg, input logic [7:0] o);
        return {pg, o};
    endfunction

    function automatic logic [22:0] exp_global(input logic [7:0] pg, input logic [7:0] o,
                                               input logic g, input logic [6:0] gp, input logic [6:0] lx);
        return {(g ? gp : lx), pg, o};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; reg_wr = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        mdl_page = 8'h00; mdl_lock = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic sp);
        @(negedge clk); reg_addr = a; reg_wdata = d; special_mode = sp; reg_wr = 1'b1;
        @(posedge clk);
        if (a == OFS) begin
            if (sp) mdl_page = d;
            else if (!mdl_lock) begin mdl_page = d; mdl_lock = 1'b1; end
        end
        @(negedge clk); reg_wr = 1'b0; reg_addr = OFS; #1;
    endtask

    task automatic probe_addr(input string req);
        cpu_offset = 8'($urandom); gpage_in = 7'($urandom); lx_upper = 7'($urandom);
        cpu_global = 1'($urandom);
        #1;
        check(req, 32'(local_addr), 32'(exp_local(mdl_page, cpu_offset)));
        check(req, 32'(global_addr),
              32'(exp_global(mdl_page, cpu_offset, cpu_global, gpage_in, lx_upper)));
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        reg_addr = OFS; #1;
        check("R1 reset value", 32'(reg_rdata), 32'h00);
        reg_addr = 8'h10; #1;
        check("R2 other offset reads zero", 32'(reg_rdata), 32'h00);
        reg_addr = OFS; #1;
        check("R7 local after reset", 32'(local_addr), 32'(exp_local(8'h00, cpu_offset)));

        // R6: neighbouring offsets change nothing and do not lock
        do_write(8'h10, 8'hAA, 1'b0);
        check("R6 write to 0x10 ignored", 32'(reg_rdata), 32'(mdl_page));
        do_write(8'h12, 8'hBB, 1'b0);
        check("R6 write to 0x12 ignored", 32'(reg_rdata), 32'(mdl_page));
        // R1/R4: first normal write accepted
        do_write(OFS, 8'h80, 1'b0);
        check("R4 first normal write", 32'(reg_rdata), 32'h80);
        check("R9 local updated next cycle", 32'(local_addr[15:8]), 32'h80);
        do_write(OFS, 8'h42, 1'b0);
        check("R4 second normal write dropped", 32'(reg_rdata), 32'h80);
        // R5/R3: special write while locked
        do_write(OFS, 8'h5C, 1'b1);
        check("R3 special write while locked", 32'(reg_rdata), 32'h5C);
        do_write(OFS, 8'h13, 1'b0);
        check("R5 lock kept after mode change", 32'(reg_rdata), 32'h5C);

        // R5: special writes before any normal write do not lock
        do_reset();
        do_write(OFS, 8'h21, 1'b1);
        do_write(OFS, 8'h22, 1'b1);
        check("R3 repeated special writes", 32'(reg_rdata), 32'h22);
        do_write(OFS, 8'h77, 1'b0);
        check("R5 special write did not lock", 32'(reg_rdata), 32'h77);
        do_write(OFS, 8'h78, 1'b0);
        check("R4 locked after normal write", 32'(reg_rdata), 32'h77);

        // R8: both sources of the upper bits
        cpu_global = 1'b1; gpage_in = 7'h7F; lx_upper = 7'h00; cpu_offset = 8'h01; #1;
        check("R8 global page select", 32'(global_addr), 32'(exp_global(8'h77, 8'h01, 1'b1, 7'h7F, 7'h00)));
        cpu_global = 1'b0; #1;
        check("R8 local expansion select", 32'(global_addr), 32'(exp_global(8'h77, 8'h01, 1'b0, 7'h7F, 7'h00)));

        // random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 39) == 0) do_reset();
            begin
                logic [7:0] a;
                a = ($urandom_range(0, 3) != 0) ? OFS : 8'($urandom);
                do_write(a, 8'($urandom), 1'($urandom));
            end
            check("R2 R4 R3 random read", 32'(reg_rdata), 32'(mdl_page));
            probe_addr("R7 R8 R9 random address");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule